// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

A synchronous memory with one write port and one read port that work in the same cycle. Each port has its own width, chosen from 1, 2, 4, 8, 9, 16, 18, 32 or 36 bits. Each port also has its own address range. The store holds 4,096 bits for the plain widths, or 4,608 bits when both widths are multiples of nine. Port depth is capacity divided by port width. A port with the smaller width sees the memory as a sequence of small words. A port with the larger width sees it as rows, and each row packs consecutive small words with the lowest address in the least significant bits.

All inputs are captured on clock edges. The write port runs on its own write clock. The read port captures its address and its read enable on the read clock, and it holds its result in a register. An optional second output register on the read clock adds one more cycle of latency. A clear input to the read-enable register forces a read in that cycle. A synchronous reset zeroes the read output and leaves the stored contents alone.

Two cases are rejected when the design is built: a width outside the supported set, and a pairing of a multiple-of-nine width with a plain width.

Top module: `mixw_sdp_ram`

## Requirements
- R1: Every address of each port is reachable. The last write address and the last read address map to the last row, and data written there reads back intact.
- R2: When the write port is narrower, read address A returns write words A*L through A*L+L-1, where L is the width ratio. Write word A*L sits in bits [WR_W-1:0] and each later word sits in the next higher WR_W bits.
- R3: When the write port is wider, read address B returns bits [(B mod L)*RD_W +: RD_W] of the write word at address B/L.
- R4: A read sampled at a read-clock edge appears on rdata right after that edge when OUT_REG is 0, and right after the following read-clock edge when OUT_REG is 1.
- R5: An edge with ren and ren_clr both low performs no read. rdata keeps its value (for OUT_REG 1, once the read already in flight has passed), whatever raddr carries.
- R6: ren_clr high performs a read at that edge even when ren is low.
- R7: If a read and a write touch the same row at the same edge, the read returns the contents from before that write. The new data is returned by a later read.
- R8: A synchronous rst forces rdata to zero. Stored contents are unchanged by it.
- R9: An edge with wen low changes no stored bit, whatever waddr and wdata carry.
- R10: A narrow write changes only its own lane of the row it falls in. The other lanes keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wen | input | 1 | Write enable, sampled on wclk |
| waddr | input | WR_AW | Write address in write-width words |
| wdata | input | WR_W | Write data |
| rclk | input | 1 | Read and output-register clock |
| rst | input | 1 | Synchronous active-high reset of the read output (read clock) |
| ren | input | 1 | Read enable, sampled on rclk |
| ren_clr | input | 1 | Clear of the read-enable register; forces a read |
| raddr | input | RD_AW | Read address in read-width words |
| rdata | output | RD_W | Read data |

## Verification
The hardest case to reach is a write and a read that land on the same row at the same edge while the two ports use different widths. Uniform random addresses almost never line up that way. About half of the random cycles therefore confine both ports to a small window of addresses, which makes row collisions and partial-lane overwrites common. Directed cycles add exact collisions, including one where the written lane is the one being read. A narrow-to-wide instance and a wide-to-narrow, nine-bit-lane instance with the output register run side by side. This covers both packing directions and both latencies.

// File: rtl/mixw_pkg.sv
package mixw_pkg;

  // widths built from nine-bit lanes (data byte plus one extra bit)
  function automatic bit is_lane9(input int w);
    return (w == 9) || (w == 18) || (w == 36);
  endfunction

  function automatic bit width_ok(input int w);
    return w inside {1, 2, 4, 8, 9, 16, 18, 32, 36};
  endfunction

  // words of width w held by the store
  function automatic int words_of(input int w);
    return is_lane9(w) ? (4608 / w) : (4096 / w);
  endfunction

  function automatic int wmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int wmin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/mixw_wr_map.sv
module mixw_wr_map #(
  parameter int WR_W   = 8,
  parameter int WIDE_W = 32,
  parameter int LANES  = 4,
  parameter int WR_AW  = 9,
  parameter int ROW_AW = 7
) (
  input  logic              wen,
  input  logic [WR_AW-1:0]  waddr,
  input  logic [WR_W-1:0]   wdata,
  output logic [LANES-1:0]  lane_we,
  output logic [ROW_AW-1:0] wrow,
  output logic [WIDE_W-1:0] wdata_wide
);

  generate
    if (WR_W == WIDE_W) begin : g_wide_wr
      // write spans a full row: every lane follows wen
      assign wrow       = waddr;
      assign lane_we    = {LANES{wen}};
      assign wdata_wide = wdata;
    end else begin : g_narrow_wr
      localparam int LANE_AW = $clog2(LANES);
      logic [LANE_AW-1:0] lane;

      // upper address bits pick the row, lower bits pick the lane (R2)
      assign wrow       = waddr[WR_AW-1 -: ROW_AW];
      assign lane       = waddr[LANE_AW-1:0];
      assign wdata_wide = {LANES{wdata}};

      always_comb begin
        lane_we = '0;
        if (wen) lane_we[lane] = 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/mixw_store.sv
module mixw_store #(
  parameter int WIDE_W = 32,
  parameter int ROWS   = 128,
  parameter int LANES  = 4,
  localparam int ROW_AW = $clog2(ROWS),
  localparam int NW     = WIDE_W / LANES
) (
  input  logic              wclk,
  input  logic [LANES-1:0]  lane_we,
  input  logic [ROW_AW-1:0] wrow,
  input  logic [WIDE_W-1:0] wdata_wide,
  input  logic              rclk,
  input  logic              rst,
  input  logic              rd_go,
  input  logic [ROW_AW-1:0] rrow,
  output logic [WIDE_W-1:0] rword
);

  logic [WIDE_W-1:0] mem [ROWS];

  // lane-masked write; untouched lanes keep their bits (R9, R10)
  always_ff @(posedge wclk) begin
    for (int i = 0; i < LANES; i++) begin
      if (lane_we[i]) mem[wrow][i*NW +: NW] <= wdata_wide[i*NW +: NW];
    end
  end

  // registered read; a write on the same edge is not yet visible (R7)
  always_ff @(posedge rclk) begin
    if (rst)        rword <= '0;
    else if (rd_go) rword <= mem[rrow];
  end

  // a write touches one lane or the whole row, never a partial set (R10)
  p_lane_shape_r10: assert property (@(posedge wclk) disable iff (rst)
    $onehot0(lane_we) || (&lane_we))
    else $error("lane write enables form an illegal pattern");

endmodule

// File: rtl/mixw_rd_sel.sv
module mixw_rd_sel #(
  parameter int RD_W    = 32,
  parameter int WIDE_W  = 32,
  parameter int LANES   = 4,
  parameter int RD_AW   = 7,
  parameter int ROW_AW  = 7,
  parameter int OUT_REG = 0
) (
  input  logic              rclk,
  input  logic              rst,
  input  logic              ren,
  input  logic              ren_clr,
  input  logic [RD_AW-1:0]  raddr,
  input  logic [WIDE_W-1:0] rword,
  output logic              rd_go,
  output logic [ROW_AW-1:0] rrow,
  output logic [RD_W-1:0]   rdata
);

  logic [RD_W-1:0] sel;

  // a cleared read-enable register reads as enabled (R6)
  assign rd_go = ren | ren_clr;

  generate
    if (RD_W == WIDE_W) begin : g_wide_rd
      assign rrow = raddr;
      assign sel  = rword;
    end else begin : g_narrow_rd
      localparam int LANE_AW = $clog2(LANES);
      logic [LANE_AW-1:0] lane_q;

      assign rrow = raddr[RD_AW-1 -: ROW_AW];

      // lane index travels with the row read (R3)
      always_ff @(posedge rclk) begin
        if (rst)        lane_q <= '0;
        else if (rd_go) lane_q <= raddr[LANE_AW-1:0];
      end

      assign sel = rword[int'(lane_q)*RD_W +: RD_W];

      p_clr_reads_r6: assert property (@(posedge rclk) disable iff (rst)
        (ren_clr && !ren) |=> (lane_q == $past(raddr[LANE_AW-1:0])))
        else $error("forced read did not capture its lane");
    end

    if (OUT_REG != 0) begin : g_out_reg
      logic [RD_W-1:0] out_q;
      logic            go_q;

      always_ff @(posedge rclk) begin
        if (rst) begin
          out_q <= '0;
          go_q  <= 1'b0;
        end else begin
          out_q <= sel;
          go_q  <= rd_go;
        end
      end
      assign rdata = out_q;

      p_hold_r5: assert property (@(posedge rclk) disable iff (rst)
        (!rd_go && !go_q) |=> $stable(rdata))
        else $error("rdata moved without a read");
    end else begin : g_no_out_reg
      assign rdata = sel;

      p_hold_r5: assert property (@(posedge rclk) disable iff (rst)
        !rd_go |=> $stable(rdata))
        else $error("rdata moved without a read");
    end
  endgenerate

  p_reset_clears_r8: assert property (@(posedge rclk)
    rst |=> (rdata == '0))
    else $error("rdata not cleared by reset");

endmodule

// File: rtl/mixw_sdp_ram.sv
module mixw_sdp_ram
  import mixw_pkg::*;
#(
  parameter int WR_W    = 8,
  parameter int RD_W    = 32,
  parameter int OUT_REG = 0,
  localparam int WR_AW  = $clog2(words_of(WR_W)),
  localparam int RD_AW  = $clog2(words_of(RD_W))
) (
  input  logic             wclk,
  input  logic             wen,
  input  logic [WR_AW-1:0] waddr,
  input  logic [WR_W-1:0]  wdata,
  input  logic             rclk,
  input  logic             rst,
  input  logic             ren,
  input  logic             ren_clr,
  input  logic [RD_AW-1:0] raddr,
  output logic [RD_W-1:0]  rdata
);

  localparam int WIDE_W   = wmax(WR_W, RD_W);
  localparam int NARROW_W = wmin(WR_W, RD_W);
  localparam int ROWS     = words_of(WIDE_W);
  localparam int ROW_AW   = $clog2(ROWS);
  localparam int LANES    = WIDE_W / NARROW_W;

  // configuration screening at build time
  generate
    if (!width_ok(WR_W) || !width_ok(RD_W)) begin : g_bad_width
      $error("port width outside the supported set");
    end
    if (is_lane9(WR_W) != is_lane9(RD_W)) begin : g_bad_mix
      $error("nine-bit-lane width paired with a plain width");
    end
    if ((WIDE_W % NARROW_W) != 0 || (LANES & (LANES - 1)) != 0) begin : g_bad_ratio
      $error("width ratio is not a power of two");
    end
  endgenerate

  logic [LANES-1:0]  lane_we;
  logic [ROW_AW-1:0] wrow;
  logic [WIDE_W-1:0] wdata_wide;
  logic              rd_go;
  logic [ROW_AW-1:0] rrow;
  logic [WIDE_W-1:0] rword;

  mixw_wr_map #(
    .WR_W   (WR_W),
    .WIDE_W (WIDE_W),
    .LANES  (LANES),
    .WR_AW  (WR_AW),
    .ROW_AW (ROW_AW)
  ) u_wr_map (
    .wen        (wen),
    .waddr      (waddr),
    .wdata      (wdata),
    .lane_we    (lane_we),
    .wrow       (wrow),
    .wdata_wide (wdata_wide)
  );

  mixw_store #(
    .WIDE_W (WIDE_W),
    .ROWS   (ROWS),
    .LANES  (LANES)
  ) u_store (
    .wclk       (wclk),
    .lane_we    (lane_we),
    .wrow       (wrow),
    .wdata_wide (wdata_wide),
    .rclk       (rclk),
    .rst        (rst),
    .rd_go      (rd_go),
    .rrow       (rrow),
    .rword      (rword)
  );

  mixw_rd_sel #(
    .RD_W    (RD_W),
    .WIDE_W  (WIDE_W),
    .LANES   (LANES),
    .RD_AW   (RD_AW),
    .ROW_AW  (ROW_AW),
    .OUT_REG (OUT_REG)
  ) u_rd_sel (
    .rclk    (rclk),
    .rst     (rst),
    .ren     (ren),
    .ren_clr (ren_clr),
    .raddr   (raddr),
    .rword   (rword),
    .rd_go   (rd_go),
    .rrow    (rrow),
    .rdata   (rdata)
  );

endmodule

// File: tb/mixw_sdp_ram_bench.sv
module mixw_sdp_ram_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst;

  // instance A: 8-bit writes, 32-bit reads, no output register
  logic       wen_a, ren_a, clr_a;
  logic [8:0] waddr_a;
  logic [7:0] wdata_a;
  logic [6:0] raddr_a;
  logic [31:0] rdata_a;

  // instance B: 36-bit writes, 9-bit reads, output register
  logic        wen_b, ren_b, clr_b;
  logic [6:0]  waddr_b;
  logic [35:0] wdata_b;
  logic [8:0]  raddr_b;
  logic [8:0]  rdata_b;

  mixw_sdp_ram #(.WR_W(8), .RD_W(32), .OUT_REG(0)) u_mixw_sdp_ram (
    .wclk(clk), .wen(wen_a), .waddr(waddr_a), .wdata(wdata_a),
    .rclk(clk), .rst(rst), .ren(ren_a), .ren_clr(clr_a),
    .raddr(raddr_a), .rdata(rdata_a)
  );

  mixw_sdp_ram #(.WR_W(36), .RD_W(9), .OUT_REG(1)) u_mixw_sdp_ram_dn (
    .wclk(clk), .wen(wen_b), .waddr(waddr_b), .wdata(wdata_b),
    .rclk(clk), .rst(rst), .ren(ren_b), .ren_clr(clr_b),
    .raddr(raddr_b), .rdata(rdata_b)
  );

  logic [7:0]  ma [512];
  logic [35:0] mb [128];
  logic [31:0] exp_a;
  logic [8:0]  stg_b, exp_b;
  int n_chk = 0;
  int n_bad = 0;

  function automatic logic [31:0] read_a(input logic [6:0] a);
    return {ma[{a, 2'd3}], ma[{a, 2'd2}], ma[{a, 2'd1}], ma[{a, 2'd0}]};
  endfunction

  function automatic logic [8:0] read_b(input logic [8:0] a);
    logic [35:0] row;
    row = mb[a[8:2]];
    return row[int'(a[1:0])*9 +: 9];
  endfunction

  task automatic idle();
    wen_a = 1'b0; ren_a = 1'b0; clr_a = 1'b0;
    wen_b = 1'b0; ren_b = 1'b0; clr_b = 1'b0;
  endtask

  // one clock: expectations from the model before the edge, writes after it
  task automatic tick(input string tag);
    if (rst) begin
      exp_a = '0; stg_b = '0; exp_b = '0;
    end else begin
      if (ren_a || clr_a) exp_a = read_a(raddr_a);
      exp_b = stg_b;
      if (ren_b || clr_b) stg_b = read_b(raddr_b);
    end
    @(posedge clk);
    #1;
    if (wen_a) ma[waddr_a] = wdata_a;
    if (wen_b) mb[waddr_b] = wdata_b;
    @(negedge clk);
    n_chk++;
    if (rdata_a !== exp_a) begin
      n_bad++;
      $display("FAIL %s port A: got %h expected %h", tag, rdata_a, exp_a);
    end
    n_chk++;
    if (rdata_b !== exp_b) begin
      n_bad++;
      $display("FAIL %s port B: got %h expected %h", tag, rdata_b, exp_b);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst = 1'b1;
    idle();
    waddr_a = '0; wdata_a = '0; raddr_a = '0;
    waddr_b = '0; wdata_b = '0; raddr_b = '0;
    exp_a = '0; stg_b = '0; exp_b = '0;
    @(negedge clk);

    // R8: reset holds outputs at zero even with reads requested
    ren_a = 1'b1; ren_b = 1'b1; clr_a = 1'b1;
    repeat (3) tick("R8");
    rst = 1'b0;
    idle();

    // fill both stores with reads off; R5: rdata must stay put
    for (int i = 0; i < 512; i++) begin
      wen_a = 1'b1; waddr_a = 9'(i); wdata_a = 8'($urandom);
      raddr_a = 7'($urandom);
      wen_b = (i < 128); waddr_b = 7'(i); wdata_b = {4'($urandom), 32'($urandom)};
      raddr_b = 9'($urandom);
      tick("R5");
    end
    idle();

    // R2: narrow bytes pack into a wide word, lowest address at the bottom
    for (int i = 0; i < 4; i++) begin
      wen_a = 1'b1; waddr_a = 9'(i); wdata_a = 8'(8'h11 * (i + 1));
      tick("R2");
    end
    idle(); ren_a = 1'b1; raddr_a = 7'd0;
    tick("R2");

    // R3: wide word split into nine-bit lanes
    idle(); wen_b = 1'b1; waddr_b = 7'd0; wdata_b = 36'h1_2345_6789;
    tick("R3");
    idle();
    for (int i = 0; i < 4; i++) begin
      ren_b = 1'b1; raddr_b = 9'(i);
      tick("R3");
    end
    idle();
    tick("R3");

    // R1: last addresses of each port
    wen_a = 1'b1; waddr_a = 9'd511; wdata_a = 8'hA5;
    wen_b = 1'b1; waddr_b = 7'd127; wdata_b = 36'hF_0F0F_0F0F;
    tick("R1");
    idle(); ren_a = 1'b1; raddr_a = 7'd127; ren_b = 1'b1; raddr_b = 9'd511;
    tick("R1");
    idle();
    tick("R1");

    // R7: same row written and read on one edge
    wen_a = 1'b1; waddr_a = 9'd8; wdata_a = 8'h5A; ren_a = 1'b1; raddr_a = 7'd2;
    wen_b = 1'b1; waddr_b = 7'd3; wdata_b = 36'h9_8765_4321; ren_b = 1'b1; raddr_b = 9'd13;
    tick("R7");
    wen_a = 1'b0; wen_b = 1'b0;
    tick("R7");
    idle();
    tick("R7");

    // R6: forced read with ren low
    clr_a = 1'b1; raddr_a = 7'd5; clr_b = 1'b1; raddr_b = 9'd21;
    tick("R6");
    idle();
    tick("R6");

    // R9: write enable low with live address and data
    waddr_a = 9'd8; wdata_a = 8'hFF; waddr_b = 7'd3; wdata_b = '1;
    tick("R9");
    ren_a = 1'b1; raddr_a = 7'd2; ren_b = 1'b1; raddr_b = 9'd13;
    tick("R9");
    idle();
    tick("R9");

    // R10: one lane rewritten, others kept
    wen_a = 1'b1; waddr_a = 9'd6; wdata_a = 8'hC3;
    tick("R10");
    idle(); ren_a = 1'b1; raddr_a = 7'd1;
    tick("R10");

    // R4: read then idle; B lags A by one cycle
    idle(); ren_a = 1'b1; raddr_a = 7'd10; ren_b = 1'b1; raddr_b = 9'd40;
    tick("R4");
    idle();
    tick("R4");
    tick("R4");

    // R8: mid-run reset clears outputs, contents survive
    rst = 1'b1;
    tick("R8");
    tick("R8");
    rst = 1'b0;
    ren_a = 1'b1; raddr_a = 7'd2; ren_b = 1'b1; raddr_b = 9'd13;
    tick("R8");
    idle();
    tick("R8");

    // random traffic, often squeezed into a small window to force collisions
    for (int i = 0; i < 1200; i++) begin
      bit tight;
      tight = 1'($urandom_range(0, 1));
      wen_a   = 1'($urandom_range(0, 1));
      waddr_a = tight ? 9'($urandom_range(0, 31)) : 9'($urandom);
      wdata_a = 8'($urandom);
      ren_a   = ($urandom_range(0, 3) != 0);
      clr_a   = ($urandom_range(0, 7) == 0);
      raddr_a = tight ? 7'($urandom_range(0, 7)) : 7'($urandom);
      wen_b   = 1'($urandom_range(0, 1));
      waddr_b = tight ? 7'($urandom_range(0, 7)) : 7'($urandom);
      wdata_b = {4'($urandom), 32'($urandom)};
      ren_b   = ($urandom_range(0, 3) != 0);
      clr_b   = ($urandom_range(0, 7) == 0);
      raddr_b = tight ? 9'($urandom_range(0, 31)) : 9'($urandom);
      tick("R2 R3 R4 R5 R6 R7 R10");
    end
    idle();
    tick("R5");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule